// File: doc/BRIEF.md
# Sticky Error Status Register Bank

This block holds the host-visible fault flags of a hardware monitor. Three 8-bit status registers capture fault events: fan tachometer counts above their limits, temperature zones outside their window, voltage-regulator hot inputs, and a small group of fixed-threshold trips. Once a flag is captured it stays set. It stays set after the fault disappears and remains set until software clears it. Software clears a flag by writing a 1 to its bit. A clear is refused for as long as the fault condition is still present.

Capture is qualified by the system sleep state. In each sleep state, an event class is either never masked, always masked, or masked only when its bit in that state's optional mask vector is 1. A masked event does not set its flag, but it does not clear a flag that is already set. A summary output reports whether any flag is set. The fixed-threshold group is excluded from this summary.

Register access uses a plain port. Reads are combinational from the address. A write with the strobe high acts on the addressed register in the cycle of the strobe.

Top module: `err_status_bank`

## Requirements
- R1: A flag becomes 1 on the clock edge after its event condition is seen unmasked, and it then stays 1 with no further event until a valid clear.
- R2: Writing a 1 to a bit position clears that flag when its condition is absent. Writing a 0 to a bit position leaves the flag unchanged.
- R3: A write of 1 to a flag whose event condition is present in that cycle leaves the flag set. When a set and a clear meet in the same cycle, the set wins.
- R4: Fan flag i (bits 0 to 3 of address 0) is set only when the count of fan i is strictly greater than the limit of fan i. A count equal to the limit does not set it.
- R5: Address 1 holds the zone 1 to 4 flags in bits 0 to 3 and the regulator-hot 1 and 2 flags in bits 4 and 5. Address 2 holds the fixed-trip flags in bits 0 and 1. Reserved bits (address 0 bits 4 to 7, address 1 bits 6 and 7, address 2 bits 2 to 7) read 0, and writes to them have no effect.
- R6: A synchronous active-low reset sets every register to 00h.
- R7: Sleep code 0 = S0, 1 = S1, 2 = S3, 3 = S4/5. S3 and S4/5 always mask the zone events. S4/5 always masks the fan events. Nothing is masked in S0, and the fixed-trip group is never masked.
- R8: Fan events are optionally masked in S1 and S3, and regulator-hot events in S3 and S4/5. The event is masked when its bit is 1 in the optional mask vector of the current state. Mask bit i is fan i (0 to 3), bit 4+j is zone j, and bit 8+k is regulator-hot k.
- R9: A masked event leaves a flag that is already set unchanged, and it does not block a clear while its condition is absent.
- R10: The summary output is 1 exactly when any flag at address 0 or 1 is 1. Fixed-trip flags never affect it.
- R11: Reads are combinational. Address 0 is fan, 1 is zone and regulator-hot, 2 is fixed-trip, and 3 reads 00h. A write acts on the addressed register only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data, 1 bits request a clear |
| rdata_o | output | 8 | Read data of the addressed register |
| host_err_o | output | 1 | Summary error flag |
| slp_state_i | input | 2 | Sleep state code |
| opt_mask_s1_i | input | 10 | Optional mask vector for S1 |
| opt_mask_s3_i | input | 10 | Optional mask vector for S3 |
| opt_mask_s45_i | input | 10 | Optional mask vector for S4/5 |
| fan_count_i | input | 32 | Four 8-bit tach counts, fan i at bits 8i+7:8i |
| fan_limit_i | input | 32 | Four 8-bit tach limits, same packing |
| zone_oor_i | input | 4 | Zone temperature out-of-range conditions |
| vrhot_i | input | 2 | Regulator-hot conditions |
| fixed_trip_i | input | 2 | Fixed-threshold trip conditions |

## Verification
A wrong mask decision or comparator shows up as a flag that is present or missing at the read port. It can be seen on the first read after the single clock edge that followed the event pulse. A clear that is lost or accepted wrongly shows on the read right after the write edge. It also shows on the summary output in the same cycle, because that output follows the stored flags combinationally. The bench sweeps every event against every sleep state, with the optional mask both on and off. This means any error in the masking table shows up as a mismatch in one register read.

// File: rtl/errbank_pkg.sv
// Shared definitions for the sticky error status bank.
// Assumes: a 2-bit address space and 8-bit registers.
package errbank_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_FAN   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENV   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FIXED = 2'd2;

    // Sleep state codes as driven on the slp_state_i port.
    typedef enum logic [1:0] {
        SLP_S0  = 2'd0,
        SLP_S1  = 2'd1,
        SLP_S3  = 2'd2,
        SLP_S45 = 2'd3
    } slp_state_e;

    // Per event class: forced mask and optional mask, for each sleep state.
    typedef struct packed {
        logic s1_force;
        logic s1_opt;
        logic s3_force;
        logic s3_opt;
        logic s45_force;
        logic s45_opt;
    } mask_policy_t;

    localparam mask_policy_t POL_FAN   = '{s1_force: 1'b0, s1_opt: 1'b1,
                                           s3_force: 1'b0, s3_opt: 1'b1,
                                           s45_force: 1'b1, s45_opt: 1'b0};
    localparam mask_policy_t POL_ZONE  = '{s1_force: 1'b0, s1_opt: 1'b0,
                                           s3_force: 1'b1, s3_opt: 1'b0,
                                           s45_force: 1'b1, s45_opt: 1'b0};
    localparam mask_policy_t POL_VRHOT = '{s1_force: 1'b0, s1_opt: 1'b0,
                                           s3_force: 1'b0, s3_opt: 1'b1,
                                           s45_force: 1'b0, s45_opt: 1'b1};

endpackage

// File: rtl/errbank_tach_cmp.sv
// Tachometer over-limit detector: one strict greater-than compare per fan.
// Assumes: counts and limits are packed fan 0 in the lowest slice.
module errbank_tach_cmp #(
    parameter int NUM_FAN = 4,
    parameter int TACH_W  = 8
) (
    input  logic [NUM_FAN*TACH_W-1:0] count_i,
    input  logic [NUM_FAN*TACH_W-1:0] limit_i,
    output logic [NUM_FAN-1:0]        over_o
);

    for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
        // Flag a fan whose count exceeds its limit (equal is not a fault).
        always_comb begin
            over_o[f] = count_i[f*TACH_W +: TACH_W] > limit_i[f*TACH_W +: TACH_W];
        end
    end

endmodule

// File: rtl/errbank_sleep_gate.sv
// Sleep-state qualifier for one class of events: it passes a condition as a
// set request unless the current sleep state masks it, either always or
// through the optional mask bit of that state.
// Assumes: the mask policy is fixed per class at elaboration.
module errbank_sleep_gate
    import errbank_pkg::*;
#(
    parameter int           N      = 4,
    parameter mask_policy_t POLICY = '0
) (
    input  slp_state_e     slp_i,
    input  logic [N-1:0]   opt_s1_i,
    input  logic [N-1:0]   opt_s3_i,
    input  logic [N-1:0]   opt_s45_i,
    input  logic [N-1:0]   cond_i,
    output logic [N-1:0]   set_req_o
);

    logic [N-1:0] masked;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Decide whether event i is suppressed in the present sleep state.
        always_comb begin
            unique case (slp_i)
                SLP_S1:  masked[i] = POLICY.s1_force  | (POLICY.s1_opt  & opt_s1_i[i]);
                SLP_S3:  masked[i] = POLICY.s3_force  | (POLICY.s3_opt  & opt_s3_i[i]);
                SLP_S45: masked[i] = POLICY.s45_force | (POLICY.s45_opt & opt_s45_i[i]);
                default: masked[i] = 1'b0;
            endcase
        end

        // Forward an unmasked condition as a set request.
        always_comb begin
            set_req_o[i] = cond_i[i] & ~masked[i];
        end
    end

endmodule

// File: rtl/errbank_sticky_reg.sv
// One sticky status register with write-one-to-clear. A clear is refused
// while the raw condition of that bit is present, and a set wins over a
// clear. Bits outside VALID are held at 0.
// Assumes: set_req is already qualified by sleep masking. cond is raw.
module errbank_sticky_reg #(
    parameter int             W     = 8,
    parameter logic [W-1:0]   VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_req_i,
    input  logic [W-1:0] cond_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_q;
    logic [W-1:0] q_d;
    logic [W-1:0] clr_ok;

    // A clear is honoured only for bits whose condition is gone.
    always_comb begin
        clr_ok = clr_i & ~cond_i;
    end

    // Next state: set has priority, otherwise hold unless cleared.
    always_comb begin
        q_d = VALID & (set_req_i | (q_q & ~clr_ok));
    end

    // Status storage with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

    for (genvar i = 0; i < W; i++) begin : g_chk
        if (VALID[i]) begin : g_valid
            assert_set_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
                set_req_i[i] |=> q_o[i]);
            assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (q_o[i] && !clr_i[i]) |=> q_o[i]);
            assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !cond_i[i] && !set_req_i[i]) |=> !q_o[i]);
            assert_clear_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (q_o[i] && cond_i[i]) |=> q_o[i]);
        end
    end

endmodule

// File: rtl/err_status_bank.sv
// Sticky error status bank: fan, zone/regulator-hot and fixed-trip status
// registers, sleep-state capture qualification, register read mux and the
// summary error flag (fixed-trip group excluded).
// Assumes: NUM_ZONE + NUM_VRHOT <= 8, NUM_FAN <= 8 and NUM_FIXED <= 8.
module err_status_bank
    import errbank_pkg::*;
#(
    parameter int NUM_FAN   = 4,
    parameter int TACH_W    = 8,
    parameter int NUM_ZONE  = 4,
    parameter int NUM_VRHOT = 2,
    parameter int NUM_FIXED = 2,
    localparam int MASK_W   = NUM_FAN + NUM_ZONE + NUM_VRHOT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [DATA_W-1:0]         rdata_o,
    output logic                      host_err_o,
    input  logic [1:0]                slp_state_i,
    input  logic [MASK_W-1:0]         opt_mask_s1_i,
    input  logic [MASK_W-1:0]         opt_mask_s3_i,
    input  logic [MASK_W-1:0]         opt_mask_s45_i,
    input  logic [NUM_FAN*TACH_W-1:0] fan_count_i,
    input  logic [NUM_FAN*TACH_W-1:0] fan_limit_i,
    input  logic [NUM_ZONE-1:0]       zone_oor_i,
    input  logic [NUM_VRHOT-1:0]      vrhot_i,
    input  logic [NUM_FIXED-1:0]      fixed_trip_i
);

    localparam int ZONE_MB  = NUM_FAN;
    localparam int VRHOT_MB = NUM_FAN + NUM_ZONE;
    localparam int VRHOT_SB = NUM_ZONE;
    localparam logic [DATA_W-1:0] FAN_VALID   = DATA_W'((1 << NUM_FAN) - 1);
    localparam logic [DATA_W-1:0] ENV_VALID   = DATA_W'((1 << (NUM_ZONE + NUM_VRHOT)) - 1);
    localparam logic [DATA_W-1:0] FIXED_VALID = DATA_W'((1 << NUM_FIXED) - 1);

    slp_state_e slp;
    assign slp = slp_state_e'(slp_state_i);

    logic [NUM_FAN-1:0]   fan_over;
    logic [NUM_FAN-1:0]   fan_set_n;
    logic [NUM_ZONE-1:0]  zone_set_n;
    logic [NUM_VRHOT-1:0] vrhot_set_n;

    logic [DATA_W-1:0] fan_cond,  fan_set,  fan_clr,  fan_q;
    logic [DATA_W-1:0] env_cond,  env_set,  env_clr,  env_q;
    logic [DATA_W-1:0] fix_cond,  fix_set,  fix_clr,  fix_q;

    errbank_tach_cmp #(
        .NUM_FAN (NUM_FAN),
        .TACH_W  (TACH_W)
    ) tach_cmp_i (
        .count_i (fan_count_i),
        .limit_i (fan_limit_i),
        .over_o  (fan_over)
    );

    errbank_sleep_gate #(
        .N      (NUM_FAN),
        .POLICY (POL_FAN)
    ) fan_gate_i (
        .slp_i     (slp),
        .opt_s1_i  (opt_mask_s1_i[NUM_FAN-1:0]),
        .opt_s3_i  (opt_mask_s3_i[NUM_FAN-1:0]),
        .opt_s45_i (opt_mask_s45_i[NUM_FAN-1:0]),
        .cond_i    (fan_over),
        .set_req_o (fan_set_n)
    );

    errbank_sleep_gate #(
        .N      (NUM_ZONE),
        .POLICY (POL_ZONE)
    ) zone_gate_i (
        .slp_i     (slp),
        .opt_s1_i  (opt_mask_s1_i[ZONE_MB +: NUM_ZONE]),
        .opt_s3_i  (opt_mask_s3_i[ZONE_MB +: NUM_ZONE]),
        .opt_s45_i (opt_mask_s45_i[ZONE_MB +: NUM_ZONE]),
        .cond_i    (zone_oor_i),
        .set_req_o (zone_set_n)
    );

    errbank_sleep_gate #(
        .N      (NUM_VRHOT),
        .POLICY (POL_VRHOT)
    ) vrhot_gate_i (
        .slp_i     (slp),
        .opt_s1_i  (opt_mask_s1_i[VRHOT_MB +: NUM_VRHOT]),
        .opt_s3_i  (opt_mask_s3_i[VRHOT_MB +: NUM_VRHOT]),
        .opt_s45_i (opt_mask_s45_i[VRHOT_MB +: NUM_VRHOT]),
        .cond_i    (vrhot_i),
        .set_req_o (vrhot_set_n)
    );

    // Place fan conditions and set requests at their register bit positions.
    always_comb begin
        fan_cond = '0;
        fan_set  = '0;
        fan_cond[NUM_FAN-1:0] = fan_over;
        fan_set[NUM_FAN-1:0]  = fan_set_n;
    end

    // Place zone and regulator-hot bits in the shared environment register.
    always_comb begin
        env_cond = '0;
        env_set  = '0;
        env_cond[NUM_ZONE-1:0]               = zone_oor_i;
        env_set[NUM_ZONE-1:0]                = zone_set_n;
        env_cond[VRHOT_SB +: NUM_VRHOT]      = vrhot_i;
        env_set[VRHOT_SB +: NUM_VRHOT]       = vrhot_set_n;
    end

    // Fixed-trip events are never sleep-masked.
    always_comb begin
        fix_cond = '0;
        fix_cond[NUM_FIXED-1:0] = fixed_trip_i;
        fix_set  = fix_cond;
    end

    // Steer write data to the addressed register as clear requests.
    always_comb begin
        fan_clr = (wr_en_i && addr_i == ADDR_FAN)   ? wdata_i : '0;
        env_clr = (wr_en_i && addr_i == ADDR_ENV)   ? wdata_i : '0;
        fix_clr = (wr_en_i && addr_i == ADDR_FIXED) ? wdata_i : '0;
    end

    errbank_sticky_reg #(
        .W     (DATA_W),
        .VALID (FAN_VALID)
    ) fan_reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req_i (fan_set),
        .cond_i    (fan_cond),
        .clr_i     (fan_clr),
        .q_o       (fan_q)
    );

    errbank_sticky_reg #(
        .W     (DATA_W),
        .VALID (ENV_VALID)
    ) env_reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req_i (env_set),
        .cond_i    (env_cond),
        .clr_i     (env_clr),
        .q_o       (env_q)
    );

    errbank_sticky_reg #(
        .W     (DATA_W),
        .VALID (FIXED_VALID)
    ) fix_reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req_i (fix_set),
        .cond_i    (fix_cond),
        .clr_i     (fix_clr),
        .q_o       (fix_q)
    );

    // Combinational read mux. The unused address reads zero.
    always_comb begin
        unique case (addr_i)
            ADDR_FAN:   rdata_o = fan_q;
            ADDR_ENV:   rdata_o = env_q;
            ADDR_FIXED: rdata_o = fix_q;
            default:    rdata_o = '0;
        endcase
    end

    // Summary flag over fan and environment flags only.
    always_comb begin
        host_err_o = |{fan_q, env_q};
    end

    // Forced masks keep clear flags clear across the masked sleep states.
    for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan_chk
        assert_fan_forced_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (slp == SLP_S45 && !fan_q[f]) |=> !fan_q[f]);
    end
    for (genvar z = 0; z < NUM_ZONE; z++) begin : g_zone_chk
        assert_zone_forced_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((slp == SLP_S3 || slp == SLP_S45) && !env_q[z]) |=> !env_q[z]);
    end
    assert_fixed_excluded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fan_q == '0 && env_q == '0) |-> !host_err_o);
    assert_reset_clears_R6: assert property (@(posedge clk)
        !rst_n |=> (fan_q == '0 && env_q == '0 && fix_q == '0));

endmodule

// File: tb/err_status_bank_tb_top.sv
// Self-checking bench: directed checks plus a sweep of every event against
// every sleep state with the optional mask on and off.
module err_status_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        host_err;
    logic [1:0]  slp = 2'd0;
    logic [9:0]  m_s1 = '0, m_s3 = '0, m_s45 = '0;
    logic [31:0] fcnt = '0;
    logic [31:0] flim = {4{8'h80}};
    logic [3:0]  zone = '0;
    logic [1:0]  vrh = '0;
    logic [1:0]  fixt = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    err_status_bank dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en_i        (wr_en),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .rdata_o        (rdata),
        .host_err_o     (host_err),
        .slp_state_i    (slp),
        .opt_mask_s1_i  (m_s1),
        .opt_mask_s3_i  (m_s3),
        .opt_mask_s45_i (m_s45),
        .fan_count_i    (fcnt),
        .fan_limit_i    (flim),
        .zone_oor_i     (zone),
        .vrhot_i        (vrh),
        .fixed_trip_i   (fixt)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'd0;
    endtask

    // Event index: 0-3 fan, 4-7 zone, 8-9 regulator-hot, 10-11 fixed trip.
    task automatic set_cond(input int ev, input bit v);
        if (ev < 4)       fcnt[ev*8 +: 8] = v ? 8'hFF : 8'h00;
        else if (ev < 8)  zone[ev-4] = v;
        else if (ev < 10) vrh[ev-8] = v;
        else              fixt[ev-10] = v;
    endtask

    task automatic pulse(input int ev);
        @(negedge clk);
        set_cond(ev, 1'b1);
        @(negedge clk);
        set_cond(ev, 1'b0);
    endtask

    task automatic clear_all();
        @(negedge clk);
        fcnt = '0; zone = '0; vrh = '0; fixt = '0;
        slp = 2'd0; m_s1 = '0; m_s3 = '0; m_s45 = '0;
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    endtask

    function automatic bit exp_masked(input int st, input int ev, input bit opt);
        if (ev < 4)       return (st == 3) || ((st == 1 || st == 2) && opt);
        else if (ev < 8)  return (st == 2 || st == 3);
        else if (ev < 10) return (st == 2 || st == 3) && opt;
        else              return 1'b0;
    endfunction

    function automatic logic [1:0] ev_addr(input int ev);
        if (ev < 4)       return 2'd0;
        else if (ev < 10) return 2'd1;
        else              return 2'd2;
    endfunction

    function automatic int ev_bit(input int ev);
        if (ev < 4)       return ev;
        else if (ev < 10) return ev - 4;
        else              return ev - 10;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 / R11: reset state of every address, unused address reads 0.
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R6 reset value", v, 0);
        end
        check("R10 reset summary", host_err, 0);

        // R4: strict greater-than compare per fan, limits differ per fan.
        for (int f = 0; f < 4; f++) begin
            for (int off = -1; off <= 1; off++) begin
                clear_all();
                @(negedge clk);
                flim[f*8 +: 8] = 8'(16*(f+1) + 3);
                fcnt[f*8 +: 8] = 8'(16*(f+1) + 3 + off);
                @(negedge clk);
                fcnt = '0; flim = {4{8'h80}};
                rd(2'd0, v);
                check("R4 tach compare", v, (off > 0) ? (1 << f) : 0);
            end
        end

        // R1: flag stays after the event goes away.
        clear_all();
        pulse(5);
        repeat (4) @(negedge clk);
        rd(2'd1, v);
        check("R1 sticky after event gone", v, 8'h02);
        check("R10 summary from env flag", host_err, 1);

        // R2: writing 0 keeps, writing 1 clears; R11: other address untouched.
        pulse(0);
        wr(2'd1, 8'hFD);
        rd(2'd1, v);
        check("R2 zero write keeps", v, 8'h02);
        rd(2'd0, v);
        check("R11 write to env leaves fan", v, 8'h01);
        wr(2'd1, 8'h02);
        rd(2'd1, v);
        check("R2 one write clears", v, 8'h00);

        // R3: clear refused while condition present, then accepted.
        clear_all();
        @(negedge clk); set_cond(2, 1'b1);
        wr(2'd0, 8'h04);
        rd(2'd0, v);
        check("R3 clear refused while active", v, 8'h04);
        @(negedge clk); set_cond(2, 1'b0);
        wr(2'd0, 8'h04);
        rd(2'd0, v);
        check("R3 clear after condition gone", v, 8'h00);

        // R5: layout of all flags and reserved bits.
        clear_all();
        @(negedge clk);
        fcnt = '1; zone = '1; vrh = '1; fixt = '1;
        @(negedge clk);
        fcnt = '0; zone = '0; vrh = '0; fixt = '0;
        rd(2'd0, v); check("R5 fan layout", v, 8'h0F);
        rd(2'd1, v); check("R5 env layout", v, 8'h3F);
        rd(2'd2, v); check("R5 fixed layout", v, 8'h03);
        wr(2'd1, 8'hC0);
        rd(2'd1, v); check("R5 reserved write ignored", v, 8'h3F);
        @(negedge clk); vrh = 2'b10;
        @(negedge clk); vrh = 2'b00;
        wr(2'd1, 8'h0F);
        rd(2'd1, v); check("R5 vrhot bits positions", v, 8'h30);

        // R6: synchronous reset mid-run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(2'd1, v); check("R6 reset clears env", v, 0);
        rd(2'd0, v); check("R6 reset clears fan", v, 0);

        // R9: masked event keeps a set flag, does not block clear.
        clear_all();
        pulse(1);
        @(negedge clk); slp = 2'd3;
        pulse(1);
        rd(2'd0, v); check("R9 masked keeps set flag", v, 8'h02);
        wr(2'd0, 8'h02);
        rd(2'd0, v); check("R9 clear in masked state", v, 8'h00);
        pulse(1);
        rd(2'd0, v); check("R9 masked event no set", v, 8'h00);

        // R10: fixed-trip flags never drive the summary.
        clear_all();
        pulse(11);
        rd(2'd2, v); check("R10 fixed flag set", v, 8'h02);
        check("R10 fixed excluded from summary", host_err, 0);
        pulse(8);
        rd(2'd1, v);
        check("R10 summary on vrhot", host_err, 1);

        // R7 / R8: sweep every event, every sleep state, optional mask on/off.
        for (int st = 0; st < 4; st++) begin
            for (int ev = 0; ev < 12; ev++) begin
                for (int opt = 0; opt < 2; opt++) begin
                    bit mk;
                    int mb;
                    clear_all();
                    @(negedge clk);
                    slp = st[1:0];
                    mb = (ev < 10) ? ev : 0;
                    if (ev < 10) begin
                        m_s1[mb] = opt[0]; m_s3[mb] = opt[0]; m_s45[mb] = opt[0];
                    end
                    pulse(ev);
                    mk = exp_masked(st, ev, opt[0]);
                    rd(ev_addr(ev), v);
                    check(mk ? "R7/R8 masked event" : "R7/R8 unmasked event",
                          v, mk ? 0 : (1 << ev_bit(ev)));
                    check("R10 summary after sweep pulse", host_err,
                          (!mk && ev < 10) ? 1 : 0);
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule